// File: doc/BRIEF.md
# Keyed Configuration Write Guard

This block protects one 8-bit configuration field, the alternate-function select of a peripheral, against stray software writes. Software first writes a 32-bit unlock key to a lock register. While the unit is unlocked, software may load an 8-bit commit mask. Every later write to the protected field changes only the bit positions whose commit-mask bit is set. All other bit positions keep their value.

The block sits on a plain register port: a write strobe, a 12-bit byte offset, 32-bit write data and combinational read data. The offsets it decodes are fixed by the surrounding register map: the lock register at 0x520, the commit mask at 0x524 and the protected field at 0x420. The protected field also drives an output, so the pad multiplexing logic can use it directly.

Top module: `key_commit_gate`

## Requirements
- R1: After reset the unit is locked (lock readback 1), the commit mask reads 0xFF, and the protected field and `altfn_o` are 0x00.
- R2: A write of exactly 0x0ACCE551 to offset 0x520 unlocks the unit, and offset 0x520 then reads 0x00000000.
- R3: A write of any other value to offset 0x520 locks the unit, and offset 0x520 then reads 0x00000001. Bits 31:1 always read 0.
- R4: A write to offset 0x524 while the unit is locked leaves the commit mask unchanged.
- R5: A write to offset 0x524 while the unit is unlocked stores wdata bits 7:0 as the commit mask. The mask reads back zero-extended to 32 bits.
- R6: A write to offset 0x420 sets bit n of the protected field to wdata bit n when commit-mask bit n is 1, and leaves bit n unchanged when it is 0. The field reads back zero-extended.
- R7: Locking and unlocking do not change the commit mask or the protected field.
- R8: A lock-register write takes effect at its own clock edge. A commit write in the very next cycle uses the new lock state.
- R9: Reads of offsets other than 0x420, 0x520 and 0x524 return 0. Writes to those other offsets change no state.
- R10: `altfn_o` always equals the value read at offset 0x420.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the current cycle |
| addr_i | input | 12 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| altfn_o | output | 8 | Current value of the protected field |

## Verification
The hardest case to reach is a commit write issued in the cycle right after a lock-register write. Every check in the normal flow leaves an idle read cycle between writes, so this case never arises there. Directed back-to-back sequences drive a relock followed at once by a commit write, and a key write followed at once by a commit write. Reading the mask back then shows which lock state the commit write used. Partial masks are also set up, including an all-zero mask, so that single field writes show both kept bits and changed bits.

// File: rtl/kcg_pkg.sv
package kcg_pkg;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned FIELD_W = 8;

  localparam logic [ADDR_W-1:0] OFF_ALTFN  = 12'h420;
  localparam logic [ADDR_W-1:0] OFF_LOCK   = 12'h520;
  localparam logic [ADDR_W-1:0] OFF_COMMIT = 12'h524;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0ACC_E551;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_ALTFN,
    SEL_LOCK,
    SEL_COMMIT
  } reg_sel_e;
endpackage

// File: rtl/kcg_lock.sv
module kcg_lock #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              locked_o
);
  logic locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   locked_q <= 1'b1;
    else if (wr_i) locked_q <= (wdata_i != KEY);
  end

  assign locked_o = locked_q;

  a_r2_key_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i == KEY) |=> !locked_o);

  a_r3_bad_key_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i != KEY) |=> locked_o);

  a_r7_lock_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(locked_o));
endmodule

// File: rtl/kcg_commit.sv
module kcg_commit #(
  parameter int unsigned FIELD_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               locked_i,
  input  logic [FIELD_W-1:0] wdata_i,
  output logic [FIELD_W-1:0] mask_o
);
  logic [FIELD_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 mask_q <= '1;
    else if (wr_i && !locked_i)  mask_q <= wdata_i;
  end

  assign mask_o = mask_q;

  a_r4_locked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i |=> $stable(mask_o));

  a_r5_unlocked_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !locked_i) |=> (mask_o == $past(wdata_i)));
endmodule

// File: rtl/kcg_masked_reg.sv
module kcg_masked_reg #(
  parameter int unsigned FIELD_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [FIELD_W-1:0] mask_i,
  input  logic [FIELD_W-1:0] wdata_i,
  output logic [FIELD_W-1:0] q_o
);
  // one enable per bit: mask gates the strobe
  for (genvar b = 0; b < FIELD_W; b++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 bit_q <= 1'b0;
      else if (wr_i && mask_i[b])  bit_q <= wdata_i[b];
    end
    assign q_o[b] = bit_q;
  end

  a_r6_masked_bits_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (((q_o ^ $past(q_o)) & ~$past(mask_i)) == '0));

  a_r6_open_bits_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((q_o & $past(mask_i)) == ($past(wdata_i) & $past(mask_i))));

  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_o));
endmodule

// File: rtl/key_commit_gate.sv
module key_commit_gate
  import kcg_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY = UNLOCK_KEY
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [FIELD_W-1:0] altfn_o
);
  localparam int unsigned PAD_W = DATA_W - FIELD_W;

  reg_sel_e           sel;
  logic               locked;
  logic [FIELD_W-1:0] commit_mask;
  logic [FIELD_W-1:0] altfn_q;

  always_comb begin
    unique case (addr_i)
      OFF_ALTFN:  sel = SEL_ALTFN;
      OFF_LOCK:   sel = SEL_LOCK;
      OFF_COMMIT: sel = SEL_COMMIT;
      default:    sel = SEL_NONE;
    endcase
  end

  kcg_lock #(.DATA_W(DATA_W), .KEY(KEY)) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (we_i && sel == SEL_LOCK),
    .wdata_i  (wdata_i),
    .locked_o (locked)
  );

  kcg_commit #(.FIELD_W(FIELD_W)) u_commit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (we_i && sel == SEL_COMMIT),
    .locked_i (locked),
    .wdata_i  (wdata_i[FIELD_W-1:0]),
    .mask_o   (commit_mask)
  );

  kcg_masked_reg #(.FIELD_W(FIELD_W)) u_altfn (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (we_i && sel == SEL_ALTFN),
    .mask_i  (commit_mask),
    .wdata_i (wdata_i[FIELD_W-1:0]),
    .q_o     (altfn_q)
  );

  always_comb begin
    unique case (sel)
      SEL_ALTFN:  rdata_o = {{PAD_W{1'b0}}, altfn_q};
      SEL_LOCK:   rdata_o = {{(DATA_W-1){1'b0}}, locked};
      SEL_COMMIT: rdata_o = {{PAD_W{1'b0}}, commit_mask};
      default:    rdata_o = '0;
    endcase
  end

  assign altfn_o = altfn_q;

  a_r7_lock_write_keeps_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFF_LOCK) |=> ($stable(commit_mask) && $stable(altfn_o)));

  a_r9_stray_write_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == SEL_NONE) |=> ($stable(commit_mask) && $stable(altfn_o) && $stable(locked)));

  a_r3_lock_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFF_LOCK) |-> (rdata_o[DATA_W-1:1] == '0));
endmodule

// File: tb/tb_key_commit_gate.sv
module tb_key_commit_gate;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [7:0]  altfn_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  key_commit_gate dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .altfn_o(altfn_o)
  );

  // {we, waddr, wdata, raddr, exp_rdata, exp_altfn}
  localparam int NV = 15;
  localparam logic [96:0] VEC [NV] = '{
    {1'b1, 12'h420, 32'h0000_005A, 12'h420, 32'h0000_005A, 8'h5A}, // R6 full mask
    {1'b1, 12'h524, 32'h0000_000F, 12'h524, 32'h0000_00FF, 8'h5A}, // R4 locked
    {1'b1, 12'h520, 32'h0ACC_E551, 12'h520, 32'h0000_0000, 8'h5A}, // R2
    {1'b1, 12'h524, 32'hABCD_12F0, 12'h524, 32'h0000_00F0, 8'h5A}, // R5
    {1'b1, 12'h520, 32'h0ACC_E550, 12'h520, 32'h0000_0001, 8'h5A}, // R3
    {1'b1, 12'h420, 32'hFFFF_FF0F, 12'h420, 32'h0000_000A, 8'h0A}, // R6 partial
    {1'b1, 12'h524, 32'h0000_0000, 12'h524, 32'h0000_00F0, 8'h0A}, // R4 R7
    {1'b1, 12'h420, 32'h0000_00A5, 12'h420, 32'h0000_00AA, 8'hAA}, // R6
    {1'b1, 12'h000, 32'hFFFF_FFFF, 12'h000, 32'h0000_0000, 8'hAA}, // R9
    {1'b1, 12'h520, 32'h0ACC_E551, 12'h520, 32'h0000_0000, 8'hAA}, // R2
    {1'b1, 12'h524, 32'h0000_0000, 12'h524, 32'h0000_0000, 8'hAA}, // R5
    {1'b1, 12'h420, 32'h0000_0055, 12'h420, 32'h0000_00AA, 8'hAA}, // R6 zero mask
    {1'b1, 12'h520, 32'hFFFF_FFFF, 12'h520, 32'h0000_0001, 8'hAA}, // R3
    {1'b1, 12'h520, 32'h0ACC_E551, 12'h524, 32'h0000_0000, 8'hAA}, // R7
    {1'b1, 12'h528, 32'h0000_0000, 12'h520, 32'h0000_0000, 8'hAA}  // R9
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk_i);
    we_i = 1'b0; addr_i = a; wdata_i = '0;
    #1;
    check(req, rdata_o, exp);
  endtask

  task automatic reset_chk();
    rst_ni = 1'b0;
    we_i = 1'b0;
    #20;
    rst_ni = 1'b1;
    rd_chk("R1 lock", 12'h520, 32'h1);
    rd_chk("R1 commit", 12'h524, 32'hFF);
    rd_chk("R1 altfn", 12'h420, 32'h0);
    check("R1 altfn_o", {24'h0, altfn_o}, 32'h0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    reset_chk();
    for (int i = 0; i < NV; i++) begin
      logic [96:0] v;
      v = VEC[i];
      if (v[96]) wr(v[95:84], v[83:52]);
      rd_chk($sformatf("vector %0d", i), v[51:40], v[39:8]);
      check("R10 altfn_o", {24'h0, altfn_o}, {24'h0, v[7:0]});
    end
    // R8: relock then commit on the very next cycle is refused
    wr(12'h520, 32'h0);
    wr(12'h524, 32'h3C);
    rd_chk("R8 relock then commit", 12'h524, 32'h0);
    // R8: key then commit on the very next cycle is accepted
    wr(12'h520, 32'h0ACC_E551);
    wr(12'h524, 32'hC3);
    rd_chk("R8 key then commit", 12'h524, 32'hC3);
    wr(12'h420, 32'hFF);
    rd_chk("R6 after R8 mask", 12'h420, 32'hEB);
    check("R10 altfn_o", {24'h0, altfn_o}, 32'hEB);
    rd_chk("R9 unmapped read", 12'h41C, 32'h0);
    reset_chk();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule